// File: doc/BRIEF.md
# Synchronous Serial Clock Output Generator

This block runs beside an asynchronous serial transmitter and produces a bit clock on a dedicated pin, so that a synchronous receiver can sample the data bits of each transmitted frame. The transmitter owns the frame: it shifts the start, data and stop bits and, at each half-bit boundary, presents a one-cycle tick together with a description of the half-period that begins. The description gives the segment kind, the data bit index and which half of the bit it is. From that description and a small set of mode controls, this block decides the level of the serial clock for that half-period.

The clock rests at the level chosen by the polarity control. It emits exactly one pulse per pulsed data bit and none during start, stop or idle time. The phase control places the pulse in the first or the second half of the bit. The pulse of the final data bit can be withheld. That final bit is index 7 or index 8, depending on the word length control. Polarity, phase and final-pulse settings are captured while the transmitter is disabled and are frozen while it is enabled. A separate pin-enable output tells the pad when to drive the clock.

Top module: `usart_sclk_gen`

## Requirements
- R1: `sclk_oe_o` equals `sclk_en_i` from one clock earlier. While `sclk_en_i` is 0 at a tick, no pulse level is produced, and `sclk_o` stays at the idle level.
- R2: While `tx_en_i` is 0, `sclk_o` equals the `pol_i` value sampled one cycle earlier. The idle level is low for polarity 0 and high for polarity 1.
- R3: For a pulsed data bit, `sclk_o` is the inverse of the idle level during one half of the bit and the idle level during the other half. With `pha_i`=0 the inverted half is the first half (`seg_late_i`=0), and with `pha_i`=1 it is the second half (`seg_late_i`=1). The new level appears in the cycle after the tick cycle.
- R4: Segment kinds are encoded on `seg_kind_i` as 0 idle, 1 start, 2 data and 3 stop. Ticks of kind 0, 1 or 3 set `sclk_o` to the idle level. As a result, a frame with N pulsed data bits shows exactly 2N clock transitions.
- R5: Data bits go out least significant first, with index 0 first. The last data bit has index 7 when `word9_i`=0 and index 8 when `word9_i`=1. Its pulse is emitted only when the latched final-pulse setting is 1. Data ticks with an index above the last index produce no pulse.
- R6: Polarity, phase and final-pulse settings are sampled on every cycle in which `tx_en_i` is 0, and they are held while `tx_en_i` is 1. Changing `pol_i`, `pha_i` or `last_pulse_i` during an enabled frame has no effect on `sclk_o`.
- R7: A synchronous active-low reset sets `sclk_o` to the current `pol_i` and clears `sclk_oe_o`.
- R8: While `tx_en_i` is 1 and `half_tick_i` is 0, `sclk_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_en_i | input | 1 | Clock pin enable control |
| pol_i | input | 1 | Idle level select |
| pha_i | input | 1 | Capture half select |
| last_pulse_i | input | 1 | Emit pulse for last data bit |
| word9_i | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| tx_en_i | input | 1 | Transmitter enabled; freezes settings |
| half_tick_i | input | 1 | One-cycle pulse at each half-bit boundary |
| seg_kind_i | input | 2 | Kind of half-period beginning at the tick |
| seg_idx_i | input | 4 | Data bit index of that half-period |
| seg_late_i | input | 1 | 1 for the second half of a bit |
| sclk_o | output | 1 | Serial clock |
| sclk_oe_o | output | 1 | Pin drive enable |

## Verification
Whole frames are generated for all four polarity and phase pairings, crossed with both word lengths and both final-pulse settings. Per frame, the transition count separates a withheld final pulse from an emitted one and 8-bit from 9-bit framing. The level seen in every half-period separates the two phases and the two polarities. Frames that toggle the mode inputs mid-frame show that the settings are frozen. A frame with the pin disabled, and idle toggling of polarity, cover the rest level. Seeded random frames then mix all of these.

// File: rtl/usart_sclk_pkg.sv
package usart_sclk_pkg;

   typedef enum logic [1:0] {
      SEG_IDLE  = 2'd0,
      SEG_START = 2'd1,
      SEG_DATA  = 2'd2,
      SEG_STOP  = 2'd3
   } seg_kind_e;

   typedef struct packed {
      logic pol;
      logic pha;
      logic last_pulse;
   } sclk_cfg_t;

   // Level of the clock for a half-period: idle level, inverted when active.
   function automatic logic half_level(input logic pol, input logic active);
      return pol ^ active;
   endfunction

endpackage

// File: rtl/usart_sclk_cfg.sv
module usart_sclk_cfg
   import usart_sclk_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tx_en_i,
   input  sclk_cfg_t cfg_i,
   output sclk_cfg_t cfg_o
);

   sclk_cfg_t cfg_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= cfg_i;
      end else if (!tx_en_i) begin
         cfg_q <= cfg_i;
      end
   end

   assign cfg_o = cfg_q;

endmodule

// File: rtl/usart_sclk_gate.sv
module usart_sclk_gate
   import usart_sclk_pkg::*;
#(
   parameter int IDX_W     = 4,
   parameter int SHORT_LEN = 8,
   parameter int LONG_LEN  = 9
) (
   input  sclk_cfg_t        cfg_i,
   input  logic             sclk_en_i,
   input  logic             word9_i,
   input  logic [1:0]       seg_kind_i,
   input  logic [IDX_W-1:0] seg_idx_i,
   input  logic             seg_late_i,
   output logic             level_o
);

   localparam logic [IDX_W-1:0] SHORT_LAST = IDX_W'(SHORT_LEN - 1);
   localparam logic [IDX_W-1:0] LONG_LAST  = IDX_W'(LONG_LEN - 1);

   seg_kind_e        kind;
   logic [IDX_W-1:0] last_idx;
   logic             is_data;
   logic             in_range;
   logic             is_last;
   logic             bit_pulsed;
   logic             half_hit;

   assign kind = seg_kind_e'(seg_kind_i);

   generate
      if (SHORT_LEN == LONG_LEN) begin : g_fixed_len
         assign last_idx = SHORT_LAST;
      end else begin : g_sel_len
         assign last_idx = word9_i ? LONG_LAST : SHORT_LAST;
      end
   endgenerate

   always_comb begin
      is_data    = (kind == SEG_DATA);
      in_range   = (seg_idx_i <= last_idx);
      is_last    = (seg_idx_i == last_idx);
      bit_pulsed = is_data && in_range && sclk_en_i && (!is_last || cfg_i.last_pulse);
      half_hit   = (seg_late_i == cfg_i.pha);
      level_o    = half_level(cfg_i.pol, bit_pulsed && half_hit);
   end

endmodule

// File: rtl/usart_sclk_drive.sv
module usart_sclk_drive #(
   parameter bit OE_REGISTERED = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pol_i,
   input  logic tx_en_i,
   input  logic half_tick_i,
   input  logic level_i,
   input  logic sclk_en_i,
   output logic sclk_o,
   output logic sclk_oe_o
);

   logic sclk_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sclk_q <= pol_i;
      end else if (!tx_en_i) begin
         sclk_q <= pol_i;
      end else if (half_tick_i) begin
         sclk_q <= level_i;
      end
   end

   assign sclk_o = sclk_q;

   generate
      if (OE_REGISTERED) begin : g_oe_reg
         logic oe_q;
         always_ff @(posedge clk) begin
            if (!rst_n) oe_q <= 1'b0;
            else        oe_q <= sclk_en_i;
         end
         assign sclk_oe_o = oe_q;
      end else begin : g_oe_comb
         assign sclk_oe_o = rst_n & sclk_en_i;
      end
   endgenerate

endmodule

// File: rtl/usart_sclk_gen.sv
module usart_sclk_gen
   import usart_sclk_pkg::*;
#(
   parameter int IDX_W         = 4,
   parameter int SHORT_LEN     = 8,
   parameter int LONG_LEN      = 9,
   parameter bit OE_REGISTERED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sclk_en_i,
   input  logic             pol_i,
   input  logic             pha_i,
   input  logic             last_pulse_i,
   input  logic             word9_i,
   input  logic             tx_en_i,
   input  logic             half_tick_i,
   input  logic [1:0]       seg_kind_i,
   input  logic [IDX_W-1:0] seg_idx_i,
   input  logic             seg_late_i,
   output logic             sclk_o,
   output logic             sclk_oe_o
);

   generate
      if (SHORT_LEN < 1 || LONG_LEN < SHORT_LEN) begin : g_bad_len
         $error("word lengths must satisfy 1 <= SHORT_LEN <= LONG_LEN");
      end
      if ((1 << IDX_W) < LONG_LEN) begin : g_bad_idx
         $error("IDX_W too narrow for LONG_LEN");
      end
   endgenerate

   sclk_cfg_t cfg_live;
   sclk_cfg_t cfg_q;
   logic      level_d;

   assign cfg_live = '{pol: pol_i, pha: pha_i, last_pulse: last_pulse_i};

   usart_sclk_cfg u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .tx_en_i (tx_en_i),
      .cfg_i   (cfg_live),
      .cfg_o   (cfg_q)
   );

   usart_sclk_gate #(
      .IDX_W     (IDX_W),
      .SHORT_LEN (SHORT_LEN),
      .LONG_LEN  (LONG_LEN)
   ) u_gate (
      .cfg_i      (cfg_q),
      .sclk_en_i  (sclk_en_i),
      .word9_i    (word9_i),
      .seg_kind_i (seg_kind_i),
      .seg_idx_i  (seg_idx_i),
      .seg_late_i (seg_late_i),
      .level_o    (level_d)
   );

   usart_sclk_drive #(
      .OE_REGISTERED (OE_REGISTERED)
   ) u_drive (
      .clk         (clk),
      .rst_n       (rst_n),
      .pol_i       (pol_i),
      .tx_en_i     (tx_en_i),
      .half_tick_i (half_tick_i),
      .level_i     (level_d),
      .sclk_en_i   (sclk_en_i),
      .sclk_o      (sclk_o),
      .sclk_oe_o   (sclk_oe_o)
   );

endmodule

// File: rtl/usart_sclk_chk.sv
module usart_sclk_chk
   import usart_sclk_pkg::*;
#(
   parameter int IDX_W     = 4,
   parameter int SHORT_LEN = 8,
   parameter int LONG_LEN  = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sclk_en_i,
   input logic             pol_i,
   input logic             word9_i,
   input logic             tx_en_i,
   input logic             half_tick_i,
   input logic [1:0]       seg_kind_i,
   input logic [IDX_W-1:0] seg_idx_i,
   input logic             seg_late_i,
   input sclk_cfg_t        cfg_q,
   input logic             sclk_o,
   input logic             sclk_oe_o
);

   localparam logic [IDX_W-1:0] SHORT_LAST = IDX_W'(SHORT_LEN - 1);
   localparam logic [IDX_W-1:0] LONG_LAST  = IDX_W'(LONG_LEN - 1);

   logic [IDX_W-1:0] last_now;
   assign last_now = word9_i ? LONG_LAST : SHORT_LAST;

   // R1
   oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> sclk_oe_o == $past(sclk_en_i));

   // R2
   idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!tx_en_i) |-> sclk_o == $past(pol_i));

   // R8
   hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && tx_en_i && !half_tick_i) |-> $stable(sclk_o));

   // R4
   non_data_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && tx_en_i && half_tick_i && seg_kind_i != SEG_DATA) |-> sclk_o == cfg_q.pol);

   // R5
   last_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && tx_en_i && half_tick_i && seg_kind_i == SEG_DATA && seg_idx_i == last_now
            && !cfg_q.last_pulse) |-> sclk_o == cfg_q.pol);

   // R3
   phase_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && tx_en_i && half_tick_i && sclk_en_i && seg_kind_i == SEG_DATA
            && seg_idx_i < SHORT_LAST)
      |-> sclk_o == (cfg_q.pol ^ ($past(seg_late_i) == cfg_q.pha)));

   // R6
   cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && tx_en_i) |-> $stable(cfg_q));

endmodule

bind usart_sclk_gen usart_sclk_chk #(
   .IDX_W     (IDX_W),
   .SHORT_LEN (SHORT_LEN),
   .LONG_LEN  (LONG_LEN)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sclk_en_i   (sclk_en_i),
   .pol_i       (pol_i),
   .word9_i     (word9_i),
   .tx_en_i     (tx_en_i),
   .half_tick_i (half_tick_i),
   .seg_kind_i  (seg_kind_i),
   .seg_idx_i   (seg_idx_i),
   .seg_late_i  (seg_late_i),
   .cfg_q       (cfg_q),
   .sclk_o      (sclk_o),
   .sclk_oe_o   (sclk_oe_o)
);

// File: tb/usart_sclk_gen_bench.sv
`timescale 1ns/1ps
module usart_sclk_gen_bench;

   localparam int HALF = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sclk_en_i = 1'b0;
   logic       pol_i = 1'b0;
   logic       pha_i = 1'b0;
   logic       last_pulse_i = 1'b0;
   logic       word9_i = 1'b0;
   logic       tx_en_i = 1'b0;
   logic       half_tick_i = 1'b0;
   logic [1:0] seg_kind_i = 2'd0;
   logic [3:0] seg_idx_i = 4'd0;
   logic       seg_late_i = 1'b0;
   logic       sclk_o;
   logic       sclk_oe_o;

   int total = 0;
   int bad = 0;
   int edges = 0;
   logic prev_sclk = 1'b0;
   int lvl_err = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   usart_sclk_gen u_usart_sclk_gen (
      .clk(clk), .rst_n(rst_n), .sclk_en_i(sclk_en_i), .pol_i(pol_i), .pha_i(pha_i),
      .last_pulse_i(last_pulse_i), .word9_i(word9_i), .tx_en_i(tx_en_i),
      .half_tick_i(half_tick_i), .seg_kind_i(seg_kind_i), .seg_idx_i(seg_idx_i),
      .seg_late_i(seg_late_i), .sclk_o(sclk_o), .sclk_oe_o(sclk_oe_o)
   );

   always @(negedge clk) begin
      if (sclk_o !== prev_sclk) edges++;
      prev_sclk = sclk_o;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Expected clock level for a half-period, from the requirements.
   function automatic logic exp_level(input logic pol, pha, lp, w9, en,
                                      input int kind, idx, input logic late);
      int last;
      last = w9 ? 8 : 7;
      if (kind != 2 || !en || idx > last) return pol;
      if (idx == last && !lp) return pol;
      return pol ^ (late == pha);
   endfunction

   function automatic int exp_edges(input logic lp, w9, en);
      int n;
      if (!en) return 0;
      n = (w9 ? 9 : 8) - (lp ? 0 : 1);
      return 2 * n;
   endfunction

   task automatic half(input logic pol, pha, lp, w9, en,
                       input int kind, idx, input logic late);
      logic e;
      @(negedge clk);
      half_tick_i = 1'b1;
      seg_kind_i  = kind[1:0];
      seg_idx_i   = idx[3:0];
      seg_late_i  = late;
      @(negedge clk);
      half_tick_i = 1'b0;
      e = exp_level(pol, pha, lp, w9, en, kind, idx, late);
      if (sclk_o !== e) lvl_err++;
      repeat (HALF - 2) @(negedge clk);
      if (sclk_o !== e) lvl_err++;
   endtask

   task automatic frame(input logic pol, pha, lp, w9, en, input bit disturb, input bit extra_idx);
      int n;
      int e0;
      n = w9 ? 9 : 8;
      @(negedge clk);
      pol_i = pol; pha_i = pha; last_pulse_i = lp; word9_i = w9; sclk_en_i = en;
      repeat (2) @(negedge clk);
      tx_en_i = 1'b1;
      @(negedge clk);
      if (disturb) begin
         pol_i = ~pol; pha_i = ~pha; last_pulse_i = ~lp;
      end
      lvl_err = 0;
      e0 = edges;
      half(pol, pha, lp, w9, en, 1, 0, 1'b0);
      half(pol, pha, lp, w9, en, 1, 0, 1'b1);
      for (int i = 0; i < n; i++) begin
         half(pol, pha, lp, w9, en, 2, i, 1'b0);
         half(pol, pha, lp, w9, en, 2, i, 1'b1);
      end
      if (extra_idx) begin
         half(pol, pha, lp, w9, en, 2, 12, 1'b0);
         half(pol, pha, lp, w9, en, 2, 12, 1'b1);
      end
      half(pol, pha, lp, w9, en, 3, 0, 1'b0);
      half(pol, pha, lp, w9, en, 3, 0, 1'b1);
      // R4 R5: transition count per frame; R3 phase levels per half
      chk(edges - e0 == exp_edges(lp, w9, en), "R4/R5 edge count", edges - e0, exp_edges(lp, w9, en));
      chk(lvl_err == 0, disturb ? "R6 frozen settings levels" : "R3 half levels", lvl_err, 0);
      chk(sclk_o === pol, "R2 rest after stop", sclk_o, pol);
      chk(sclk_oe_o === en, "R1 pin enable", sclk_oe_o, en);
      pol_i = pol; pha_i = pha; last_pulse_i = lp;
      @(negedge clk);
      tx_en_i = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      #(5.0 * 150000);
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      pol_i = 1'b1;
      repeat (3) @(negedge clk);
      // R7: reset state
      chk(sclk_o === 1'b1, "R7 reset level", sclk_o, 1);
      chk(sclk_oe_o === 1'b0, "R7 reset oe", sclk_oe_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R2: idle level follows polarity one cycle later
      pol_i = 1'b0;
      @(negedge clk);
      chk(sclk_o === 1'b0, "R2 idle follows pol", sclk_o, 0);
      pol_i = 1'b1;
      @(negedge clk);
      chk(sclk_o === 1'b1, "R2 idle follows pol", sclk_o, 1);
      // R1: oe tracks enable with one cycle delay
      sclk_en_i = 1'b1;
      @(negedge clk);
      chk(sclk_oe_o === 1'b1, "R1 oe rises", sclk_oe_o, 1);
      // R8: ticks absent while enabled, clock holds
      tx_en_i = 1'b1;
      pol_i = 1'b0;
      repeat (4) @(negedge clk);
      chk(sclk_o === 1'b1, "R8 hold without tick", sclk_o, 1);
      pol_i = 1'b1;
      tx_en_i = 1'b0;
      @(negedge clk);
      // Directed sweep: R3 R4 R5
      for (int c = 0; c < 16; c++) begin
         frame(c[0], c[1], c[2], c[3], 1'b1, 1'b0, 1'b0);
      end
      // R1: disabled pin produces no pulses
      frame(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      frame(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      // R6: settings changed mid-frame are ignored
      frame(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
      frame(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
      // R5: data index above last produces no pulse
      frame(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
      // Seeded random frames
      for (int r = 0; r < 24; r++) begin
         logic [5:0] v;
         v = 6'($urandom);
         frame(v[0], v[1], v[2], v[3], v[4] | v[5], v[5], 1'b0);
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule